// File: doc/BRIEF.md
# Thread Context Run-Enable Controller

This block sits beside the thread scheduler of a multithreaded core and decides which of its hardware thread contexts may run. Any context can issue one of two control instructions: halt-all, which stops every other context, or wake-all, which restarts them. The block holds a global enable bit, a registered copy of each context's master flag, and a run bit for every context. Only a context whose master flag is set can act. A wake-all leaves alone any context that is parked waiting for an interrupt. Neither instruction ever touches the run bit of the context that issued it.

Each accepted instruction takes effect on a single clock edge. The issuer receives a read-back word that holds the control word as it stood before that edge. The global enable bit is at bit 0 of that word and every other bit reads as zero. If both instruction strobes arrive in the same cycle, the request is refused: an error pulse goes out and no state changes.

Top module: `ctxen_ctrl`

## Requirements
- R1: While `rst_n` is low: `run_o` has only bit 0 set, `gen_en_o` is 0, `rdback_o` is 0, `clash_o` is 0, and the stored master flags mark context 0 as the only master.
- R2: A cycle with exactly one strobe high completes on the next rising edge. After that edge `rdback_o` equals the control word from before the edge: bit 0 is the old `gen_en_o` and bits above 0 are zero. This holds whether or not the issuer is a master.
- R3: A halt-all from a master issuer clears `gen_en_o` and clears the run bit of every context other than the issuer, after one edge.
- R4: A wake-all from a master issuer sets `gen_en_o` and sets the run bit of every context that is neither the issuer nor flagged in `wfi_i`, after one edge.
- R5: A context whose `wfi_i` bit is high during a master wake-all keeps its run bit unchanged.
- R6: The issuer's own run bit is unchanged by its own halt-all or wake-all.
- R7: An instruction from an issuer whose stored master flag is 0 leaves `gen_en_o` and `run_o` unchanged. Only `rdback_o` updates.
- R8: When `halt_all_i` and `wake_all_i` are high together, `clash_o` is high for exactly the one cycle after the edge, and `run_o`, `gen_en_o` and `rdback_o` keep their values. `clash_o` is low after any other cycle.
- R9: The stored master flags copy `master_i` on every rising edge. An instruction uses the flags captured on the edge before the one that applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_all_i | input | 1 | Halt-all instruction strobe |
| wake_all_i | input | 1 | Wake-all instruction strobe |
| issuer_i | input | IDW | Index of the issuing context |
| master_i | input | NCTX | Master flag per context, registered each edge |
| wfi_i | input | NCTX | Wait-for-interrupt flag per context |
| run_o | output | NCTX | Run enable per context |
| gen_en_o | output | 1 | Global enable bit |
| rdback_o | output | CW | Control word before the last accepted instruction |
| clash_o | output | 1 | One-cycle pulse on a rejected double strobe |

## Verification
Every result of an instruction (run bits, global enable, read-back word and clash pulse) is due on the first rising edge after the strobe cycle. The bench drives on falling edges and checks at the next falling edge, which is half a period after that edge. A change to the master flags takes one extra edge to reach the stored copy. The bench therefore checks both an instruction issued in the same cycle as the flag change, which must see the old flag, and one issued a cycle later. The clash pulse is checked high at the first falling edge and low again at the second.

// File: rtl/ctxen_pkg.sv
package ctxen_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_HALT  = 2'd1,
    OP_WAKE  = 2'd2,
    OP_CLASH = 2'd3
  } op_e;
endpackage

// File: rtl/ctxen_decode.sv
module ctxen_decode
  import ctxen_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            halt_req,
  input  logic            wake_req,
  input  logic [IDW-1:0]  issuer,
  input  logic [NCTX-1:0] master_q,
  output op_e             op,
  output logic            is_master
);
  // Strobe pair to operation kind
  always_comb begin
    unique case ({wake_req, halt_req})
      2'b01:   op = OP_HALT;
      2'b10:   op = OP_WAKE;
      2'b11:   op = OP_CLASH;
      default: op = OP_IDLE;
    endcase
  end

  // Master flag of the issuer; an out-of-range index counts as non-master
  always_comb begin
    is_master = 1'b0;
    for (int k = 0; k < NCTX; k++) begin
      if (issuer == IDW'(k)) is_master = master_q[k];
    end
  end
endmodule

// File: rtl/ctxen_runmask.sv
module ctxen_runmask
  import ctxen_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  op_e             op,
  input  logic            is_master,
  input  logic [IDW-1:0]  issuer,
  input  logic [NCTX-1:0] run_q,
  input  logic [NCTX-1:0] wfi,
  output logic [NCTX-1:0] run_d
);
  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    logic self_c;
    assign self_c = (issuer == IDW'(k));
    always_comb begin
      run_d[k] = run_q[k];
      if (is_master && !self_c) begin
        if (op == OP_HALT) run_d[k] = 1'b0;
        else if (op == OP_WAKE && !wfi[k]) run_d[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctxen_ctrl.sv
module ctxen_ctrl
  import ctxen_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int CW   = 32,
  parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_all_i,
  input  logic            wake_all_i,
  input  logic [IDW-1:0]  issuer_i,
  input  logic [NCTX-1:0] master_i,
  input  logic [NCTX-1:0] wfi_i,
  output logic [NCTX-1:0] run_o,
  output logic            gen_en_o,
  output logic [CW-1:0]   rdback_o,
  output logic            clash_o
);
  localparam logic [NCTX-1:0] RST_ONE = NCTX'(1);

  op_e             op;
  logic            is_master;
  logic [NCTX-1:0] master_q;
  logic [NCTX-1:0] run_q, run_d;
  logic            gen_q, gen_d;
  logic [CW-1:0]   rd_q, rd_d;
  logic            clash_q, clash_d;
  logic            accept;

  ctxen_decode #(.NCTX(NCTX), .IDW(IDW)) u_dec (
    .halt_req  (halt_all_i),
    .wake_req  (wake_all_i),
    .issuer    (issuer_i),
    .master_q  (master_q),
    .op        (op),
    .is_master (is_master)
  );

  ctxen_runmask #(.NCTX(NCTX), .IDW(IDW)) u_mask (
    .op        (op),
    .is_master (is_master),
    .issuer    (issuer_i),
    .run_q     (run_q),
    .wfi       (wfi_i),
    .run_d     (run_d)
  );

  assign accept = (op == OP_HALT) || (op == OP_WAKE);

  // Next-state logic
  always_comb begin
    gen_d   = gen_q;
    rd_d    = rd_q;
    clash_d = (op == OP_CLASH);
    if (accept) begin
      rd_d = {{(CW-1){1'b0}}, gen_q};
      if (is_master) gen_d = (op == OP_WAKE);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= RST_ONE;
      run_q    <= RST_ONE;
      gen_q    <= 1'b0;
      rd_q     <= '0;
      clash_q  <= 1'b0;
    end else begin
      master_q <= master_i;
      clash_q  <= clash_d;
      if (accept) begin
        run_q <= run_d;
        gen_q <= gen_d;
        rd_q  <= rd_d;
      end
    end
  end

  assign run_o    = run_q;
  assign gen_en_o = gen_q;
  assign rdback_o = rd_q;
  assign clash_o  = clash_q;
endmodule

// File: rtl/ctxen_ctrl_chk.sv
module ctxen_ctrl_chk #(
  parameter int NCTX = 4,
  parameter int CW   = 32,
  parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt_all_i,
  input logic            wake_all_i,
  input logic [IDW-1:0]  issuer_i,
  input logic [NCTX-1:0] master_q,
  input logic [NCTX-1:0] wfi_i,
  input logic [NCTX-1:0] run_o,
  input logic            gen_en_o,
  input logic [CW-1:0]   rdback_o,
  input logic            clash_o
);
  logic [NCTX-1:0] self_m;
  logic            single, mst;
  assign self_m = NCTX'(1) << issuer_i;
  assign single = halt_all_i ^ wake_all_i;
  assign mst    = (master_q & self_m) != '0;

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    single |=> rdback_o == {{(CW-1){1'b0}}, $past(gen_en_o)});
  a_r3_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_all_i && !wake_all_i && mst) |=> !gen_en_o && ((run_o & ~$past(self_m)) == '0));
  a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_all_i && !halt_all_i && mst) |=>
      gen_en_o && ((~run_o & ~$past(self_m) & ~$past(wfi_i)) == '0));
  a_r5_wfi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_all_i && !halt_all_i && mst) |=> ((run_o ^ $past(run_o)) & $past(wfi_i)) == '0);
  a_r6_issuer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    single |=> ((run_o ^ $past(run_o)) & $past(self_m)) == '0);
  a_r7_nonmaster: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !mst) |=> $stable(run_o) && $stable(gen_en_o));
  a_r8_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_all_i && wake_all_i) |=> clash_o && $stable(run_o) && $stable(gen_en_o) && $stable(rdback_o));
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_all_i && wake_all_i) |=> !clash_o);
endmodule

bind ctxen_ctrl ctxen_ctrl_chk #(.NCTX(NCTX), .CW(CW), .IDW(IDW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt_all_i (halt_all_i),
  .wake_all_i (wake_all_i),
  .issuer_i   (issuer_i),
  .master_q   (master_q),
  .wfi_i      (wfi_i),
  .run_o      (run_o),
  .gen_en_o   (gen_en_o),
  .rdback_o   (rdback_o),
  .clash_o    (clash_o)
);

// File: tb/ctxen_ctrl_test.sv
module ctxen_ctrl_test;
  localparam int NCTX = 4;
  localparam int CW   = 32;
  localparam int IDW  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            halt_all_i = 1'b0, wake_all_i = 1'b0;
  logic [IDW-1:0]  issuer_i = '0;
  logic [NCTX-1:0] master_i = 4'b0001;
  logic [NCTX-1:0] wfi_i = '0;
  logic [NCTX-1:0] run_o;
  logic            gen_en_o, clash_o;
  logic [CW-1:0]   rdback_o;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ctxen_ctrl #(.NCTX(NCTX), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .halt_all_i(halt_all_i), .wake_all_i(wake_all_i),
    .issuer_i(issuer_i), .master_i(master_i), .wfi_i(wfi_i),
    .run_o(run_o), .gen_en_o(gen_en_o), .rdback_o(rdback_o), .clash_o(clash_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one strobe cycle at a falling edge; return at the next falling edge
  task automatic issue(input logic h, input logic w, input int who);
    halt_all_i = h; wake_all_i = w; issuer_i = IDW'(who);
    @(negedge clk);
    halt_all_i = 1'b0; wake_all_i = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [3:0] run,
                              input logic en, input logic [31:0] rd);
    chk({req, " run"}, 32'(run_o), 32'(run));
    chk({req, " enable"}, 32'(gen_en_o), 32'(en));
    chk({req, " readback"}, rdback_o, rd);
    chk({req, " clash"}, 32'(clash_o), 32'd0);
  endtask

  task automatic t_reset();   // R1
    expect_state("R1", 4'b0001, 1'b0, 32'd0);
  endtask

  task automatic t_wake_master();   // R4, R2
    issue(1'b0, 1'b1, 0);
    expect_state("R4", 4'b1111, 1'b1, 32'd0);
  endtask

  task automatic t_nonmaster();   // R7, R2
    issue(1'b1, 1'b0, 2);
    expect_state("R7", 4'b1111, 1'b1, 32'd1);
  endtask

  task automatic t_halt_master();   // R3
    issue(1'b1, 1'b0, 0);
    expect_state("R3", 4'b0001, 1'b0, 32'd1);
  endtask

  task automatic t_wfi();   // R5
    wfi_i = 4'b0100;
    issue(1'b0, 1'b1, 0);
    wfi_i = '0;
    expect_state("R5", 4'b1011, 1'b1, 32'd0);
  endtask

  task automatic t_other_master();   // R9, R6: ctx1 takes over and halts others
    master_i = 4'b0010;
    @(negedge clk);
    issue(1'b1, 1'b0, 1);
    expect_state("R6", 4'b0010, 1'b0, 32'd1);
  endtask

  task automatic t_halted_issuer();   // R6: halted ctx3 wakes others, stays halted
    master_i = 4'b1000;
    @(negedge clk);
    issue(1'b0, 1'b1, 3);
    expect_state("R6", 4'b0111, 1'b1, 32'd0);
  endtask

  task automatic t_clash();   // R8
    issue(1'b1, 1'b1, 3);
    chk("R8 pulse", 32'(clash_o), 32'd1);
    chk("R8 run", 32'(run_o), 32'(4'b0111));
    chk("R8 enable", 32'(gen_en_o), 32'd1);
    chk("R8 readback", rdback_o, 32'd0);
    @(negedge clk);
    chk("R8 pulse end", 32'(clash_o), 32'd0);
  endtask

  task automatic t_master_latency();   // R9
    master_i = 4'b0100;
    issue(1'b1, 1'b0, 2);   // stored flags still mark ctx3 only
    expect_state("R9 old flag", 4'b0111, 1'b1, 32'd1);
    issue(1'b1, 1'b0, 2);
    expect_state("R9 new flag", 4'b0100, 1'b0, 32'd1);
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wake_master();
    t_nonmaster();
    t_halt_master();
    t_wfi();
    t_other_master();
    t_halted_issuer();
    t_clash();
    t_master_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule